// File: doc/BRIEF.md
# Transmit Request Scheduler for Message Objects

This block keeps the transmit requests for a bank of message objects (32 by default) and decides which one the protocol core sends next. Each object holds a valid flag, a direction flag, a remote-answer flag, an identifier, a pending-request flag and a fresh-data flag. Software configures objects through a write port. It raises or withdraws requests by object index. A received remote frame whose identifier matches a transmit object that answers remote frames raises that object's request with no software involvement.

When the core is ready and the block is idle, the block picks the pending, valid, transmit-direction object with the lowest index. It reports the choice with a one-cycle start pulse and holds the index for the whole frame. The core ends the frame with a done or a fail strobe. A success retires the request. A failure either leaves the request queued for another attempt or, when retries are turned off (time-triggered operation), retires it and raises a one-cycle failure event. Arbitration takes place only between frames.

Top module: `txq_sched`

## Requirements
- R1: After reset, no request or fresh-data flag is set, `tx_busy` and `tx_start` are 0, and every object is invalid.
- R2: A `cpu_set` strobe sets both the request flag and the fresh-data flag of object `cpu_idx` on the next cycle. A `cpu_clr` strobe clears only the request flag.
- R3: When idle with `core_ready` high, the block starts the lowest-index eligible object. `tx_start` is high for exactly one cycle, `tx_idx` gives the index, and `tx_busy` stays high until the frame ends.
- R4: An object is eligible only if it is valid (`cfg_valid`=1), set to transmit (`cfg_dir_tx`=1, 0 means receive) and has a pending request.
- R5: While a frame is in progress, no new start is issued and `tx_idx` does not change, even if a lower-index object becomes pending.
- R6: A `tx_done` strobe clears the request flag and the fresh-data flag of the object that was sent.
- R7: If `cpu_set` hits the in-flight object after its start, the request stays pending after `tx_done`, so the new data goes out in a later frame.
- R8: With `retry_en`=1, `tx_fail` leaves the request pending, raises no failure event, and the object is started again.
- R9: With `retry_en`=0, `tx_fail` clears the request flag and drives `fail_evt` high for exactly one cycle, with `tx_idx` still giving the failed object.
- R10: A `rx_remote` strobe sets the request flag of every valid transmit object that has remote answering enabled and whose identifier equals `rx_remote_id`. It leaves all other objects unchanged.
- R11: If `cpu_set` and `cpu_clr` address the same object in the same cycle, the clear wins.
- R12: An object invalidated while pending keeps its request flag but is skipped. Once it is made valid again it is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retry_en | input | 1 | 1: requeue after a failed attempt; 0: retire and report |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Object addressed by the configuration write |
| cfg_valid | input | 1 | Object valid flag |
| cfg_dir_tx | input | 1 | 1 = transmit object, 0 = receive object |
| cfg_rmt_en | input | 1 | Object answers matching remote frames |
| cfg_id | input | ID_W | Object identifier |
| cpu_set | input | 1 | Raise request and fresh-data flag of `cpu_idx` |
| cpu_clr | input | 1 | Withdraw request of `cpu_idx` |
| cpu_idx | input | IDX_W | Object addressed by set/clear |
| rx_remote | input | 1 | A remote frame was received |
| rx_remote_id | input | ID_W | Identifier of the received remote frame |
| core_ready | input | 1 | Core can accept a new frame |
| tx_start | output | 1 | One-cycle pulse: a frame starts |
| tx_idx | output | IDX_W | Index of the object in flight |
| tx_busy | output | 1 | A frame is in progress |
| tx_done | input | 1 | Core reports successful completion |
| tx_fail | input | 1 | Core reports lost arbitration or error |
| fail_evt | output | 1 | One-cycle pulse: attempt dropped with retries off |
| pend_vec | output | N | Request flag of every object |
| newdat_vec | output | N | Fresh-data flag of every object |

## Verification
The bench loads several objects at once and checks that they drain in index order. It checks that objects which are invalid or set to receive are skipped, and that an invalidated object is sent once it is valid again. A design that checked eligibility on the request flag alone would start the wrong object. A lower-index request raised during a frame must not disturb `tx_idx`. A refresh of the in-flight object must survive its completion, or the newer data would be lost silently. Both failure policies are covered: a design that swapped them would either repeat a frame in time-triggered mode or drop a frame that should be retried. Remote frames are sent with near-miss identifiers and with remote answering disabled, to catch a match that is too wide.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef enum logic [0:0] {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } txq_state_e;

  // Whether a finished attempt retires the request of the in-flight object.
  function automatic logic retire_on(input logic done, input logic fail,
                                     input logic retry, input logic renewed);
    logic r;
    if (done)      r = !renewed;
    else if (fail) r = !retry && !renewed;
    else           r = 1'b0;
    return r;
  endfunction

  // Whether the fresh-data flag is cleared along with the retirement.
  function automatic logic drop_newdat(input logic done, input logic renewed);
    return done && !renewed;
  endfunction

endpackage

// File: rtl/txq_obj_bank.sv
module txq_obj_bank #(
  parameter int N    = 32,
  parameter int ID_W = 11,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_valid,
  input  logic             cfg_dir_tx,
  input  logic             cfg_rmt_en,
  input  logic [ID_W-1:0]  cfg_id,
  input  logic             cpu_set,
  input  logic             cpu_clr,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic             rx_remote,
  input  logic [ID_W-1:0]  rx_remote_id,
  input  logic             ret_rq,
  input  logic             ret_nd,
  input  logic [IDX_W-1:0] ret_idx,
  output logic [N-1:0]     pend_vec,
  output logic [N-1:0]     newdat_vec,
  output logic [N-1:0]     elig_vec,
  output logic [N-1:0]     rhit_vec
);

  logic [N-1:0] valid_q, dir_q, rmt_q;

  for (genvar i = 0; i < N; i++) begin : g_obj
    logic [ID_W-1:0] id_q;
    logic            hit_cfg, hit_set, hit_clr, hit_ret;

    assign hit_cfg = cfg_we  && (cfg_idx == IDX_W'(i));
    assign hit_set = cpu_set && (cpu_idx == IDX_W'(i));
    assign hit_clr = cpu_clr && (cpu_idx == IDX_W'(i));
    assign hit_ret = ret_rq  && (ret_idx == IDX_W'(i));

    assign rhit_vec[i] = rx_remote && valid_q[i] && dir_q[i] && rmt_q[i]
                         && (id_q == rx_remote_id);
    assign elig_vec[i] = valid_q[i] && dir_q[i] && pend_vec[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        dir_q[i]   <= 1'b0;
        rmt_q[i]   <= 1'b0;
        id_q       <= '0;
      end else if (hit_cfg) begin
        valid_q[i] <= cfg_valid;
        dir_q[i]   <= cfg_dir_tx;
        rmt_q[i]   <= cfg_rmt_en;
        id_q       <= cfg_id;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_vec[i]   <= 1'b0;
        newdat_vec[i] <= 1'b0;
      end else begin
        if (hit_clr)                      pend_vec[i] <= 1'b0;
        else if (hit_set || rhit_vec[i])  pend_vec[i] <= 1'b1;
        else if (hit_ret)                 pend_vec[i] <= 1'b0;

        if (hit_set)                      newdat_vec[i] <= 1'b1;
        else if (hit_ret && ret_nd)       newdat_vec[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/txq_pick.sv
module txq_pick #(
  parameter int N = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_vec[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/txq_ctl.sv
module txq_ctl #(
  parameter int N = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retry_en,
  input  logic             core_ready,
  input  logic             pick_any,
  input  logic [IDX_W-1:0] pick_idx,
  input  logic             cpu_set,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic             tx_done,
  input  logic             tx_fail,
  output logic             tx_start,
  output logic             tx_busy,
  output logic [IDX_W-1:0] tx_idx,
  output logic             fail_evt,
  output logic             ev_launch,
  output logic             ev_end,
  output logic             ret_rq,
  output logic             ret_nd
);
  import txq_pkg::*;

  txq_state_e      state_q;
  logic [IDX_W-1:0] cur_q;
  logic            start_q, fail_q, renew_q;
  logic            act_done, act_fail;

  assign ev_launch = (state_q == ST_IDLE) && core_ready && pick_any;
  assign act_done  = (state_q == ST_ACTIVE) && tx_done;
  assign act_fail  = (state_q == ST_ACTIVE) && tx_fail && !tx_done;
  assign ev_end    = act_done || act_fail;
  assign ret_rq    = retire_on(act_done, act_fail, retry_en, renew_q);
  assign ret_nd    = drop_newdat(act_done, renew_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      start_q <= 1'b0;
      fail_q  <= 1'b0;
      renew_q <= 1'b0;
    end else begin
      start_q <= ev_launch;
      fail_q  <= act_fail && !retry_en;
      if (ev_launch) begin
        state_q <= ST_ACTIVE;
        cur_q   <= pick_idx;
        renew_q <= 1'b0;
      end else if (ev_end) begin
        state_q <= ST_IDLE;
      end else if (state_q == ST_ACTIVE && cpu_set && cpu_idx == cur_q) begin
        renew_q <= 1'b1;
      end
    end
  end

  assign tx_start = start_q;
  assign tx_busy  = (state_q == ST_ACTIVE);
  assign tx_idx   = cur_q;
  assign fail_evt = fail_q;

endmodule

// File: rtl/txq_sched.sv
module txq_sched #(
  parameter int N    = 32,
  parameter int ID_W = 11,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retry_en,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_valid,
  input  logic             cfg_dir_tx,
  input  logic             cfg_rmt_en,
  input  logic [ID_W-1:0]  cfg_id,
  input  logic             cpu_set,
  input  logic             cpu_clr,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic             rx_remote,
  input  logic [ID_W-1:0]  rx_remote_id,
  input  logic             core_ready,
  output logic             tx_start,
  output logic [IDX_W-1:0] tx_idx,
  output logic             tx_busy,
  input  logic             tx_done,
  input  logic             tx_fail,
  output logic             fail_evt,
  output logic [N-1:0]     pend_vec,
  output logic [N-1:0]     newdat_vec
);

  logic [N-1:0]     elig_vec, rhit_vec;
  logic             pick_any, ev_launch, ev_end, ret_rq, ret_nd;
  logic [IDX_W-1:0] pick_idx;

  txq_obj_bank #(.N(N), .ID_W(ID_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_dir_tx(cfg_dir_tx), .cfg_rmt_en(cfg_rmt_en), .cfg_id(cfg_id),
    .cpu_set(cpu_set), .cpu_clr(cpu_clr), .cpu_idx(cpu_idx),
    .rx_remote(rx_remote), .rx_remote_id(rx_remote_id),
    .ret_rq(ret_rq), .ret_nd(ret_nd), .ret_idx(tx_idx),
    .pend_vec(pend_vec), .newdat_vec(newdat_vec),
    .elig_vec(elig_vec), .rhit_vec(rhit_vec)
  );

  txq_pick #(.N(N)) u_pick (
    .req_vec(elig_vec), .any(pick_any), .idx(pick_idx)
  );

  txq_ctl #(.N(N)) u_ctl (
    .clk(clk), .rst_n(rst_n), .retry_en(retry_en), .core_ready(core_ready),
    .pick_any(pick_any), .pick_idx(pick_idx),
    .cpu_set(cpu_set), .cpu_idx(cpu_idx),
    .tx_done(tx_done), .tx_fail(tx_fail),
    .tx_start(tx_start), .tx_busy(tx_busy), .tx_idx(tx_idx),
    .fail_evt(fail_evt), .ev_launch(ev_launch), .ev_end(ev_end),
    .ret_rq(ret_rq), .ret_nd(ret_nd)
  );

endmodule

// File: rtl/txq_sched_chk.sv
module txq_sched_chk #(
  parameter int N = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             retry_en,
  input logic             tx_start,
  input logic             tx_busy,
  input logic [IDX_W-1:0] tx_idx,
  input logic             tx_done,
  input logic             tx_fail,
  input logic             fail_evt,
  input logic             ev_launch,
  input logic             ret_rq,
  input logic             cpu_set,
  input logic [IDX_W-1:0] cpu_idx,
  input logic             rx_remote,
  input logic [N-1:0]     elig_vec,
  input logic [N-1:0]     pend_vec
);

  logic [IDX_W-1:0] last_idx;
  logic             last_ret_clean;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_idx       <= '0;
      last_ret_clean <= 1'b0;
    end else begin
      last_idx       <= tx_idx;
      last_ret_clean <= ret_rq && !rx_remote && !(cpu_set && cpu_idx == tx_idx);
    end
  end

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> tx_busy);

  p_launch_elig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_launch |-> elig_vec != '0);

  p_idx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_start) |-> $stable(tx_idx));

  p_no_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_done && !tx_fail) |=> !tx_start);

  p_fail_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |-> $past(tx_busy && tx_fail && !tx_done && !retry_en));

  p_fail_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> !fail_evt);

  always_comb begin
    if (rst_n && last_ret_clean) begin
      a_retired_r6: assert (!pend_vec[last_idx]);
    end
  end

endmodule

bind txq_sched txq_sched_chk #(.N(N)) u_sched_chk (
  .clk(clk), .rst_n(rst_n), .retry_en(retry_en),
  .tx_start(tx_start), .tx_busy(tx_busy), .tx_idx(tx_idx),
  .tx_done(tx_done), .tx_fail(tx_fail), .fail_evt(fail_evt),
  .ev_launch(ev_launch), .ret_rq(ret_rq),
  .cpu_set(cpu_set), .cpu_idx(cpu_idx), .rx_remote(rx_remote),
  .elig_vec(elig_vec), .pend_vec(pend_vec)
);

// File: tb/txq_sched_bench.sv
module txq_sched_bench;
  localparam int N = 32;
  localparam int ID_W = 11;
  localparam int IDX_W = $clog2(N);
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic retry_en = 1, cfg_we = 0, cfg_valid = 0, cfg_dir_tx = 0, cfg_rmt_en = 0;
  logic [IDX_W-1:0] cfg_idx = '0, cpu_idx = '0;
  logic [ID_W-1:0] cfg_id = '0, rx_remote_id = '0;
  logic cpu_set = 0, cpu_clr = 0, rx_remote = 0, core_ready = 0;
  logic tx_done = 0, tx_fail = 0;
  logic tx_start, tx_busy, fail_evt;
  logic [IDX_W-1:0] tx_idx;
  logic [N-1:0] pend_vec, newdat_vec;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txq_sched #(.N(N), .ID_W(ID_W)) u_txq_sched (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_cfg(input int idx, input bit v, input bit d, input bit r, input int id);
    cfg_we = 1; cfg_idx = IDX_W'(idx); cfg_valid = v; cfg_dir_tx = d;
    cfg_rmt_en = r; cfg_id = ID_W'(id);
    tick(1); cfg_we = 0;
  endtask

  task automatic do_set(input int idx);
    cpu_set = 1; cpu_idx = IDX_W'(idx); tick(1); cpu_set = 0;
  endtask

  task automatic do_clr(input int idx);
    cpu_clr = 1; cpu_idx = IDX_W'(idx); tick(1); cpu_clr = 0;
  endtask

  task automatic expect_start(input int idx, input string req);
    bit seen = 0;
    for (int k = 0; k < 20 && !seen; k++) begin
      if (tx_start) seen = 1; else tick(1);
    end
    chk(req, "start seen", int'(seen), 1);
    chk(req, "start index", int'(tx_idx), idx);
    chk(req, "busy at start", int'(tx_busy), 1);
    tick(1);
    chk(req, "start is one cycle", int'(tx_start), 0);
  endtask

  task automatic finish_ok;
    tx_done = 1; tick(1); tx_done = 0;
  endtask

  task automatic t_reset;
    chk("R1", "pend", int'(pend_vec != 0), 0);
    chk("R1", "newdat", int'(newdat_vec != 0), 0);
    chk("R1", "busy", int'(tx_busy), 0);
    chk("R1", "start", int'(tx_start), 0);
  endtask

  task automatic t_set_clear;
    core_ready = 0;
    do_set(5);
    chk("R2", "pend after set", int'(pend_vec[5]), 1);
    chk("R2", "newdat after set", int'(newdat_vec[5]), 1);
    do_clr(5);
    chk("R2", "pend after clear", int'(pend_vec[5]), 0);
    chk("R2", "newdat kept", int'(newdat_vec[5]), 1);
    cpu_set = 1; cpu_clr = 1; cpu_idx = 6; tick(1); cpu_set = 0; cpu_clr = 0;
    chk("R11", "clear beats set", int'(pend_vec[6]), 0);
  endtask

  task automatic t_priority;
    core_ready = 0;
    do_cfg(3, 1, 1, 0, 3); do_cfg(7, 1, 1, 0, 7); do_cfg(20, 1, 1, 0, 20);
    do_set(20); do_set(7); do_set(3);
    core_ready = 1;
    expect_start(3, "R3");
    finish_ok;
    chk("R6", "pend cleared", int'(pend_vec[3]), 0);
    chk("R6", "newdat cleared", int'(newdat_vec[3]), 0);
    chk("R3", "busy after done", int'(tx_busy), 0);
    expect_start(7, "R3");
    finish_ok;
    expect_start(20, "R3");
    finish_ok;
    core_ready = 0;
  endtask

  task automatic t_invalid;
    core_ready = 0;
    do_cfg(2, 0, 1, 0, 2); do_cfg(9, 1, 0, 0, 9); do_cfg(12, 1, 1, 0, 12);
    do_set(2); do_set(9); do_set(12);
    core_ready = 1;
    expect_start(12, "R4");
    finish_ok;
    tick(3);
    chk("R4", "receive/invalid not started", int'(tx_busy), 0);
    chk("R12", "invalid keeps pend", int'(pend_vec[2]), 1);
    do_cfg(2, 1, 1, 0, 2);
    expect_start(2, "R12");
    finish_ok;
    core_ready = 0;
    do_clr(9);
  endtask

  task automatic t_no_reselect;
    core_ready = 0;
    do_cfg(10, 1, 1, 0, 10); do_cfg(1, 1, 1, 0, 1);
    do_set(10);
    core_ready = 1;
    expect_start(10, "R5");
    do_set(1);
    for (int k = 0; k < 3; k++) begin
      chk("R5", "no start while busy", int'(tx_start), 0);
      chk("R5", "index held", int'(tx_idx), 10);
      tick(1);
    end
    finish_ok;
    expect_start(1, "R5");
    finish_ok;
    core_ready = 0;
  endtask

  task automatic t_renew;
    do_cfg(4, 1, 1, 0, 4);
    do_set(4);
    core_ready = 1;
    expect_start(4, "R7");
    do_set(4);
    finish_ok;
    chk("R7", "pend after renewed done", int'(pend_vec[4]), 1);
    expect_start(4, "R7");
    finish_ok;
    chk("R7", "pend after second done", int'(pend_vec[4]), 0);
    core_ready = 0;
  endtask

  task automatic t_retry;
    do_cfg(8, 1, 1, 0, 8);
    retry_en = 1;
    do_set(8);
    core_ready = 1;
    expect_start(8, "R8");
    tx_fail = 1; tick(1); tx_fail = 0;
    chk("R8", "no fail event", int'(fail_evt), 0);
    chk("R8", "still pending", int'(pend_vec[8]), 1);
    expect_start(8, "R8");
    finish_ok;
    core_ready = 0;
  endtask

  task automatic t_noretry;
    retry_en = 0;
    do_set(8);
    core_ready = 1;
    expect_start(8, "R9");
    tx_fail = 1; tick(1); tx_fail = 0;
    chk("R9", "fail event", int'(fail_evt), 1);
    chk("R9", "fail index", int'(tx_idx), 8);
    chk("R9", "pend cleared", int'(pend_vec[8]), 0);
    tick(1);
    chk("R9", "fail event one cycle", int'(fail_evt), 0);
    tick(2);
    chk("R9", "no relaunch", int'(tx_busy), 0);
    retry_en = 1;
    core_ready = 0;
  endtask

  task automatic t_remote;
    core_ready = 0;
    do_cfg(13, 1, 1, 1, 'h123); do_cfg(14, 1, 1, 1, 'h123);
    do_cfg(15, 1, 1, 0, 'h123); do_cfg(16, 1, 1, 1, 'h124);
    rx_remote = 1; rx_remote_id = 'h123; tick(1); rx_remote = 0;
    chk("R10", "match 13", int'(pend_vec[13]), 1);
    chk("R10", "match 14", int'(pend_vec[14]), 1);
    chk("R10", "remote disabled 15", int'(pend_vec[15]), 0);
    chk("R10", "other id 16", int'(pend_vec[16]), 0);
    chk("R10", "newdat untouched", int'(newdat_vec[13]), 0);
    do_clr(13); do_clr(14);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1;
    tick(1);
    t_set_clear();
    t_priority();
    t_invalid();
    t_no_reselect();
    t_renew();
    t_retry();
    t_noretry();
    t_remote();
    tick(2);
    summary();
  end

endmodule